// File: doc/BRIEF.md
# MDIO Management Command Engine

This block is a management-bus master for Ethernet PHYs. A processor controls it through one 32-bit command word. The processor first writes the operation, the PHY address, the register number and, for a write, the 16-bit value. It then writes the same word again with the go bit set. The engine sends a clause-22 management frame on the clock and data pins, and keeps the busy bit high until the last bit time has ended. The processor learns that the transfer is complete by polling that same word.

For a read, the engine releases the data pin before the turnaround. It checks that the PHY pulls the line low in the second turnaround slot, then clocks in sixteen data bits. The value it receives and a no-response flag both land in the command word. The management clock comes from the system clock through a parameterised divider. The engine drives the clock low between transfers and runs it only while a frame is in flight.

Top module: `mdio_cmd_engine`

## Requirements
- R1: After reset, `reg_rdata` reads all zeros, `mdc` is low and `mdio_oe` is low.
- R2: A write with bit 29 clear while idle stores the fields: op at bits 27:26, PHY address at bits 25:21, register number at bits 20:16, value at bits 15:0. All four read back unchanged. Bits 31:30 always read 0, and bit 28 cannot be written.
- R3: A write with bit 29 set while idle starts a transfer. It takes its fields from that same write, and bit 29 reads 1 from the following cycle. Bit 29 returns to 0 exactly 128*DIV_HALF system cycles after the start write is taken.
- R4: `mdc` stays low while idle. During a transfer it has a period of 2*DIV_HALF system cycles with equal high and low halves. Its first rising edge comes DIV_HALF cycles after the start.
- R5: The frame is 64 bits, sent MSB first: 32 ones, start pattern 01, two opcode bits, five PHY address bits, five register bits, two turnaround bits, then sixteen data bits. `mdio_o` changes only just after `mdc` falls.
- R6: A write frame uses opcode 01, turnaround 10 and the stored value as data. It drives `mdio_oe` for all 64 bit times.
- R7: A read frame uses opcode 10 and drives `mdio_oe` only for the first 46 bit times. On the rising `mdc` edges of bit times 48 to 63, `mdio_i` is sampled MSB first into bits 15:0.
- R8: Bit 28 (no-response) is set when `mdio_i` is high at the rising edge of bit time 47 of a read. Every start clears it, and a write transfer never sets it.
- R9: Any write to the command word while bit 29 reads 1 has no effect on the fields or on the frame in flight.
- R10: An op field value other than 10 (including 00 and 11) runs a write frame with opcode 01. The op field still reads back as written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr_en | input | 1 | Command word write strobe |
| reg_wdata | input | 32 | Command word write data |
| reg_rdata | output | 32 | Command word read value |
| mdc | output | 1 | Management clock to the PHY |
| mdio_o | output | 1 | Management data driven out |
| mdio_oe | output | 1 | Output enable for the management data pin |
| mdio_i | input | 1 | Management data sampled from the pin |

## Verification
A bit-index or shift error inside the frame shows on the pin within the same transfer. The captured 64-bit wire image is then wrong, and the read value in the command word is displaced, by the time busy drops. A divider fault shows in the measured MDC rise spacing within the first two bit times and in the total busy length. A field latch that is not guarded while busy shows in the fields read back at the end of the transfer in which the stray write was made. A bad turnaround check shows in the no-response bit as soon as that read completes.

// File: rtl/mdio_cmd_pkg.sv
package mdio_cmd_pkg;
    localparam int FRAME_BITS = 64;
    localparam int IDX_W      = 6;
    localparam int TA_FIRST   = 46;
    localparam int TA_SECOND  = 47;
    localparam int DATA_FIRST = 48;

    localparam int GO_BIT     = 29;
    localparam int NORESP_BIT = 28;

    localparam logic [1:0] OPC_READ  = 2'b10;
    localparam logic [1:0] OPC_WRITE = 2'b01;

    typedef struct packed {
        logic [1:0]  op;
        logic [4:0]  phy;
        logic [4:0]  regad;
        logic [15:0] data;
        logic        noresp;
    } cmd_word_t;
endpackage

// File: rtl/mdio_mdc_gen.sv
module mdio_mdc_gen #(
    parameter int DIV_HALF = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic mdc,
    output logic rise_stb,
    output logic fall_stb
);
    localparam int CNT_W = (DIV_HALF > 1) ? $clog2(DIV_HALF) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(DIV_HALF - 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             mdc;
    } gen_t;

    gen_t s_q, s_d;
    logic wrap;

    assign wrap = run && (s_q.cnt == CNT_LAST);

    always_comb begin
        s_d = s_q;
        if (!run) begin
            s_d.cnt = '0;
            s_d.mdc = 1'b0;
        end else if (wrap) begin
            s_d.cnt = '0;
            s_d.mdc = ~s_q.mdc;
        end else begin
            s_d.cnt = s_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign mdc      = s_q.mdc;
    assign rise_stb = wrap && !s_q.mdc;
    assign fall_stb = wrap &&  s_q.mdc;

    // R4: counter never leaves its half-period range
    p_cnt_in_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.cnt <= CNT_LAST);

    // R4: a rise strobe is followed by a high clock level
    p_rise_gives_high_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rise_stb |=> s_q.mdc);
endmodule

// File: rtl/mdio_frame_shifter.sv
module mdio_frame_shifter
    import mdio_cmd_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        launch,
    input  logic        op_read,
    input  logic [4:0]  phy,
    input  logic [4:0]  regad,
    input  logic [15:0] wr_data,
    input  logic        rise_stb,
    input  logic        fall_stb,
    input  logic        mdio_i,
    output logic        active,
    output logic        xfer_done,
    output logic        mdio_o,
    output logic        mdio_oe,
    output logic [15:0] rd_data,
    output logic        rd_noresp
);
    localparam logic [IDX_W-1:0] IDX_LAST  = IDX_W'(FRAME_BITS - 1);
    localparam logic [IDX_W-1:0] IDX_TA1   = IDX_W'(TA_FIRST);
    localparam logic [IDX_W-1:0] IDX_TA2   = IDX_W'(TA_SECOND);
    localparam logic [IDX_W-1:0] IDX_DATA0 = IDX_W'(DATA_FIRST);

    typedef struct packed {
        logic                  active;
        logic                  is_read;
        logic [IDX_W-1:0]      idx;
        logic [FRAME_BITS-1:0] shreg;
        logic                  oe;
        logic [15:0]           rd_data;
        logic                  noresp;
    } shf_t;

    shf_t s_q, s_d;
    logic [FRAME_BITS-1:0] frame;
    logic [IDX_W-1:0]      idx_next;

    always_comb begin
        frame = {32'hFFFF_FFFF, 2'b01,
                 op_read ? OPC_READ : OPC_WRITE,
                 phy, regad,
                 op_read ? 2'b11 : 2'b10,
                 op_read ? 16'h0000 : wr_data};
    end

    assign idx_next  = s_q.idx + 1'b1;
    assign xfer_done = s_q.active && fall_stb && (s_q.idx == IDX_LAST);

    always_comb begin
        s_d = s_q;
        if (launch && !s_q.active) begin
            s_d.active  = 1'b1;
            s_d.is_read = op_read;
            s_d.idx     = '0;
            s_d.shreg   = frame;
            s_d.oe      = 1'b1;
            s_d.rd_data = '0;
            s_d.noresp  = 1'b0;
        end else if (s_q.active) begin
            if (rise_stb && s_q.is_read) begin
                if (s_q.idx == IDX_TA2) begin
                    s_d.noresp = mdio_i;
                end
                if (s_q.idx >= IDX_DATA0) begin
                    s_d.rd_data = {s_q.rd_data[14:0], mdio_i};
                end
            end
            if (fall_stb) begin
                if (s_q.idx == IDX_LAST) begin
                    s_d.active = 1'b0;
                    s_d.oe     = 1'b0;
                    s_d.shreg  = '1;
                end else begin
                    s_d.idx   = idx_next;
                    s_d.shreg = {s_q.shreg[FRAME_BITS-2:0], 1'b1};
                    s_d.oe    = !(s_q.is_read && (idx_next >= IDX_TA1));
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q       <= '0;
            s_q.shreg <= '1;
        end else begin
            s_q <= s_d;
        end
    end

    assign active    = s_q.active;
    assign mdio_o    = s_q.shreg[FRAME_BITS-1];
    assign mdio_oe   = s_q.oe;
    assign rd_data   = s_q.rd_data;
    assign rd_noresp = s_q.noresp;

    // R5: the driven bit moves only on a falling-edge strobe
    p_out_moves_on_fall_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.active && !fall_stb) |=> $stable(mdio_o));

    // R6: a write frame keeps the pin driven throughout
    p_write_drives_all_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.active && !s_q.is_read) |-> mdio_oe);

    // R7: the pin is released from the first turnaround slot of a read
    p_read_releases_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.active && s_q.is_read && (s_q.idx >= IDX_TA1)) |-> !mdio_oe);

    // R7: nothing is driven outside a transfer
    p_idle_released_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !s_q.active |-> !mdio_oe);
endmodule

// File: rtl/mdio_cmd_engine.sv
module mdio_cmd_engine
    import mdio_cmd_pkg::*;
#(
    parameter int DIV_HALF = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_wr_en,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        mdc,
    output logic        mdio_o,
    output logic        mdio_oe,
    input  logic        mdio_i
);
    cmd_word_t   s_q, s_d;
    logic        busy;
    logic        launch;
    logic        xfer_done;
    logic        rise_stb;
    logic        fall_stb;
    logic [15:0] rd_data;
    logic        rd_noresp;
    logic        unused_wbits;

    assign unused_wbits = ^{reg_wdata[31:30], reg_wdata[NORESP_BIT]};
    assign launch = reg_wr_en && !busy && reg_wdata[GO_BIT];

    always_comb begin
        s_d = s_q;
        if (reg_wr_en && !busy) begin
            s_d.op    = reg_wdata[27:26];
            s_d.phy   = reg_wdata[25:21];
            s_d.regad = reg_wdata[20:16];
            s_d.data  = reg_wdata[15:0];
            if (reg_wdata[GO_BIT]) begin
                s_d.noresp = 1'b0;
            end
        end
        if (xfer_done && (s_q.op == OPC_READ)) begin
            s_d.data   = rd_data;
            s_d.noresp = rd_noresp;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    mdio_mdc_gen #(
        .DIV_HALF (DIV_HALF)
    ) u_mdc_gen (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (busy),
        .mdc      (mdc),
        .rise_stb (rise_stb),
        .fall_stb (fall_stb)
    );

    mdio_frame_shifter u_shifter (
        .clk       (clk),
        .rst_n     (rst_n),
        .launch    (launch),
        .op_read   (reg_wdata[27:26] == OPC_READ),
        .phy       (reg_wdata[25:21]),
        .regad     (reg_wdata[20:16]),
        .wr_data   (reg_wdata[15:0]),
        .rise_stb  (rise_stb),
        .fall_stb  (fall_stb),
        .mdio_i    (mdio_i),
        .active    (busy),
        .xfer_done (xfer_done),
        .mdio_o    (mdio_o),
        .mdio_oe   (mdio_oe),
        .rd_data   (rd_data),
        .rd_noresp (rd_noresp)
    );

    assign reg_rdata = {2'b00, busy, s_q.noresp, s_q.op, s_q.phy, s_q.regad, s_q.data};

    // R3: a go write taken while idle raises busy
    p_start_sets_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr_en && !busy && reg_wdata[GO_BIT]) |=> busy);

    // R9: fields hold while a transfer runs
    p_busy_ignore_r9: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable({s_q.op, s_q.phy, s_q.regad}));

    // R4: the management clock rests low while idle
    p_mdc_idle_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mdc);

    // R8: a non-read transfer leaves the no-response bit clear
    p_noresp_read_only_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_done && (s_q.op != OPC_READ)) |=> !s_q.noresp);
endmodule

// File: tb/mdio_cmd_engine_tb_top.sv
module mdio_cmd_engine_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int DIV_HALF   = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr_en = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        mdc, mdio_o, mdio_oe;
    logic        mdio_i = 1'b1;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    int          k = 64;
    logic [63:0] cap_o, cap_oe;
    logic [15:0] phy_rd = '0;
    logic        phy_silent = 1'b0;
    int          rt0, rt1, ft0;

    mdio_cmd_engine #(.DIV_HALF(DIV_HALF)) dut_i (
        .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe),
        .mdio_i(mdio_i)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic phy_drive(int idx);
        if (idx >= 48 && idx <= 63) return phy_rd[63-idx];
        if (idx == 47) return phy_silent;
        return 1'b1;
    endfunction

    // PHY model: captures the wire on rising MDC, changes its drive afterwards
    always @(posedge mdc) begin
        if (k < 64) begin
            cap_o[63-k]  = mdio_o;
            cap_oe[63-k] = mdio_oe;
            if (k == 0) rt0 = cyc;
            if (k == 1) rt1 = cyc;
        end
        k = k + 1;
        mdio_i = phy_drive(k);
    end
    always @(negedge mdc) if (k == 1) ft0 = cyc;

    task automatic check(input logic ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [63:0] exp_frame(logic [1:0] op, logic [4:0] phy, logic [4:0] ra, logic [15:0] d);
        logic rd;
        rd = (op == 2'b10);
        return {32'hFFFF_FFFF, 2'b01, rd ? 2'b10 : 2'b01, phy, ra, rd ? 2'b11 : 2'b10, rd ? 16'h0 : d};
    endfunction

    function automatic logic [31:0] pack(logic go, logic [1:0] op, logic [4:0] phy, logic [4:0] ra, logic [15:0] d);
        return {2'b00, go, 1'b0, op, phy, ra, d};
    endfunction

    task automatic reg_write(input logic [31:0] w);
        @(negedge clk);
        reg_wr_en = 1'b1;
        reg_wdata = w;
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    task automatic run_txn(input logic [1:0] op, input logic [4:0] phy, input logic [4:0] ra,
                           input logic [15:0] d, input logic [15:0] rdv, input logic silent,
                           input logic mid_write);
        int n;
        logic rd;
        logic [63:0] ef;
        logic [15:0] data_exp;
        logic [31:0] junk;
        rd = (op == 2'b10);
        phy_rd = rdv;
        phy_silent = silent;
        reg_write(pack(1'b0, op, phy, ra, d));
        k = 0;
        mdio_i = 1'b1;
        junk = {2'b11, 1'b1, 1'b1, ~op, ~phy, ~ra, ~d};
        reg_write(pack(1'b1, op, phy, ra, d));
        n = 0;
        do begin
            @(negedge clk);
            n++;
            if (n == 10) check(reg_rdata[29] == 1'b1, "R3 busy during transfer", 64'(reg_rdata[29]), 64'd1);
            if (mid_write && n == 20) begin reg_wr_en = 1'b1; reg_wdata = junk; end
            else if (mid_write && n == 21) reg_wr_en = 1'b0;
        end while (reg_rdata[29] && n < 100000);
        check(n == 128*DIV_HALF, "R3 busy length", 64'(n), 64'(128*DIV_HALF));
        check(k == 64, "R5 rising edge count", 64'(k), 64'd64);
        ef = exp_frame(op, phy, ra, d);
        if (rd) begin
            check(cap_o[63:18] == ef[63:18], "R7 read frame header", {18'h0, cap_o[63:18]}, {18'h0, ef[63:18]});
            check(cap_oe == {{46{1'b1}}, 18'h0}, "R7 read oe pattern", cap_oe, {{46{1'b1}}, 18'h0});
        end else begin
            check(cap_o == ef, (op == 2'b01) ? "R6 write frame" : "R10 odd op sends write", cap_o, ef);
            check(cap_oe == '1, "R6 write oe", cap_oe, '1);
        end
        data_exp = rd ? rdv : d;
        check(reg_rdata == {2'b00, 1'b0, rd & silent, op, phy, ra, data_exp},
              mid_write ? "R9 fields after busy write" : (rd ? "R8 read result word" : "R2 word after write"),
              64'(reg_rdata), 64'({2'b00, 1'b0, rd & silent, op, phy, ra, data_exp}));
        check(!mdc && !mdio_oe, "R4 idle pins", {62'h0, mdc, mdio_oe}, 64'h0);
    endtask

    initial begin
        #(CLK_PERIOD*150000);
        errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_c0de));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(reg_rdata == 32'h0, "R1 reset word", 64'(reg_rdata), 64'h0);
        check(!mdc && !mdio_oe, "R1 reset pins", {62'h0, mdc, mdio_oe}, 64'h0);

        // R2 field store and readback, bits 31:30 and 28 not writable
        reg_write(32'hD5AB_CDEF & ~32'h2000_0000);
        check(reg_rdata == (32'hD5AB_CDEF & 32'h0FFF_FFFF), "R2 readback",
              64'(reg_rdata), 64'(32'hD5AB_CDEF & 32'h0FFF_FFFF));
        repeat (5) @(negedge clk);
        check(!mdc && !mdio_oe, "R4 no clock without go", {62'h0, mdc, mdio_oe}, 64'h0);

        // directed write, all-zero fields; MDC timing R4
        run_txn(2'b01, 5'h00, 5'h00, 16'h0000, 16'h0, 1'b0, 1'b0);
        check(rt1 - rt0 == 2*DIV_HALF, "R4 mdc period", 64'(rt1 - rt0), 64'(2*DIV_HALF));
        check(ft0 - rt0 == DIV_HALF, "R4 mdc high half", 64'(ft0 - rt0), 64'(DIV_HALF));
        // extreme read values
        run_txn(2'b10, 5'h1F, 5'h1F, 16'h0000, 16'hFFFF, 1'b0, 1'b0);
        run_txn(2'b10, 5'h01, 5'h10, 16'hFFFF, 16'h0001, 1'b0, 1'b0);
        // R8 PHY does not answer, then a following write clears the flag
        run_txn(2'b10, 5'h05, 5'h02, 16'h0, 16'hA5A5, 1'b1, 1'b0);
        run_txn(2'b01, 5'h05, 5'h02, 16'h8001, 16'h0, 1'b0, 1'b0);
        // R10 odd op codes
        run_txn(2'b11, 5'h0C, 5'h03, 16'h1357, 16'h0, 1'b0, 1'b0);
        run_txn(2'b00, 5'h13, 5'h1C, 16'hC3C3, 16'h0, 1'b0, 1'b0);
        // R9 writes during busy ignored, for both frame kinds
        run_txn(2'b01, 5'h0A, 5'h15, 16'h5A5A, 16'h0, 1'b0, 1'b1);
        run_txn(2'b10, 5'h11, 5'h07, 16'h0, 16'h3C96, 1'b0, 1'b1);

        for (int i = 0; i < 10; i++) begin
            logic [1:0] op;
            logic sil;
            op  = 2'($urandom_range(0, 3));
            sil = (op == 2'b10) && ($urandom_range(0, 3) == 0);
            run_txn(op, 5'($urandom), 5'($urandom), 16'($urandom), 16'($urandom), sil, 1'($urandom_range(0, 1)));
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule